// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

The block is a watchdog timer with a small register port that is written in a single cycle. Software picks a timeout period as a power of two and then sets a sticky enable bit. From then on a 32-bit down-counter runs. The counter is reloaded only when an exact 8-bit key is written to a dedicated restart register. If software fails to write the key before the counter runs out, the block raises a system reset request for a fixed number of cycles. After that it starts counting again.

The timeout register holds two 4-bit codes. The low code sets the period loaded when the watchdog is first enabled. The high code sets the period used for every later reload, whether that reload comes from a key write or from the end of a reset pulse. A code value `i` selects a period of `2^(BASE_EXP+i)` cycles. With the default `BASE_EXP` of 16 the period runs from 2^16 to 2^31 cycles.

Control is a three-state machine:
- **ST_IDLE**: the counter tracks the initial period and no request is raised.
- **ST_COUNT**: the counter counts down.
- **ST_BITE**: the reset request is driven.

The transitions are:
- **arm**: ST_IDLE to ST_COUNT, taken once enable is set.
- **kick**: ST_COUNT to ST_COUNT with a reload, taken on a correct key write.
- **expire**: ST_COUNT to ST_BITE, taken when the count runs out.
- **rearm**: ST_BITE to ST_COUNT, taken after `BITE_LEN` cycles.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control and timeout registers read as 0, and `rst_req` is low.
- R2: The control register sits at byte offset 0x00. Bit 0 is the enable bit and bit 1 is a stored mode bit. Both read back in the same positions, and the other bits read 0. The mode bit does not change the response: expiry always raises the reset request.
- R3: Once set, the enable bit stays 1 until the block's own reset. Writing 0 to bit 0 has no effect on it.
- R4: The timeout register sits at offset 0x04. Bits [7:0] can be written and read back, and bits above 7 read 0. A change of code takes effect at the next load of the counter.
- R5: Code `i` in timeout bits [3:0] sets the initial period `P = 2^(BASE_EXP+i)`. `rst_req` rises exactly `P+1` clock edges after the edge on which the enable write is taken.
- R6: Writing a value whose bits [7:0] equal 0x76 to offset 0x0C while counting reloads the counter with the period of code bits [7:4]. `rst_req` then rises exactly that many edges after the write edge.
- R7: Writing any other value to offset 0x0C has no effect on the count.
- R8: While enable is 0, `rst_req` stays low however long the block runs.
- R9: `rst_req` stays high for exactly `BITE_LEN` cycles. Counting then resumes with the bits [7:4] period, so the next request rises `BITE_LEN + P_rel` edges after the previous rise.
- R10: Key writes are ignored while enable is 0 and while `rst_req` is high.
- R11: Offset 0x0C and unmapped offsets read 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | System reset request |

## Verification
The bench builds the block with `BASE_EXP` = 2 and keeps `BITE_LEN` = 8. This shrinks code 3 to 32 cycles, code 5 to 128 cycles and code 2 to 16 cycles. Within a few hundred cycles the bench can therefore reach the first expiry, a full reset pulse, the resumed count, key reloads, a rejected key, and a code change that applies only at the next load. With the default exponent the same sequence would need more than 2^16 cycles for each expiry.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_BITE  = 2'd2
    } wdg_state_e;

    localparam logic [7:0] RESTART_KEY = 8'h76;
    localparam int         OFF_CTRL    = 'h00;
    localparam int         OFF_RANGE   = 'h04;
    localparam int         OFF_KICK    = 'h0C;

endpackage

// File: rtl/wdg_regfile.sv
module wdg_regfile
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en_o,
    output logic              mode_o,
    output logic [3:0]        init_code_o,
    output logic [3:0]        rel_code_o,
    output logic              kick_o
);

    logic       en_q;
    logic       mode_q;
    logic [7:0] range_q;
    logic       sel_ctrl, sel_range, sel_kick;

    assign sel_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
    assign sel_range = (bus_addr == ADDR_W'(OFF_RANGE));
    assign sel_kick  = (bus_addr == ADDR_W'(OFF_KICK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mode_q  <= 1'b0;
            range_q <= 8'h00;
        end else if (bus_we) begin
            if (sel_ctrl) begin
                // enable is set-only; mode bit is plain storage
                if (bus_wdata[0]) en_q <= 1'b1;
                mode_q <= bus_wdata[1];
            end
            if (sel_range) range_q <= bus_wdata[7:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)       bus_rdata[1:0] = {mode_q, en_q};
        else if (sel_range) bus_rdata[7:0] = range_q;
    end

    assign kick_o      = bus_we && sel_kick && (bus_wdata[7:0] == RESTART_KEY);
    assign en_o        = en_q;
    assign mode_o      = mode_q;
    assign init_code_o = range_q[3:0];
    assign rel_code_o  = range_q[7:4];

    // R3: enable cannot be cleared by software
    p_en_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int BASE_EXP = 16,
    parameter int BITE_LEN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       kick_i,
    input  logic [3:0] init_code_i,
    input  logic [3:0] rel_code_i,
    output logic       rst_req_o
);

    localparam int BITE_W = (BITE_LEN > 1) ? $clog2(BITE_LEN) : 1;
    localparam logic [BITE_W-1:0] BITE_LAST = BITE_W'(BITE_LEN - 1);

    function automatic logic [CNT_W-1:0] period(input logic [3:0] code);
        period = {{(CNT_W-1){1'b0}}, 1'b1} << (BASE_EXP + int'(code));
    endfunction

    wdg_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BITE_W-1:0] bite_q, bite_d;
    logic [CNT_W-1:0]  p_init, p_rel;

    assign p_init = period(init_code_i);
    assign p_rel  = period(rel_code_i);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bite_d  = bite_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d  = p_init;
                bite_d = '0;
                if (en_i) state_d = ST_COUNT;           // arm
            end
            ST_COUNT: begin
                if (kick_i) begin
                    cnt_d = p_rel;                      // kick
                end else if (cnt_q <= CNT_W'(1)) begin
                    state_d = ST_BITE;                  // expire
                    cnt_d   = '0;
                    bite_d  = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_BITE: begin
                if (bite_q == BITE_LAST) begin
                    state_d = ST_COUNT;                 // rearm
                    cnt_d   = p_rel;
                end else begin
                    bite_d = bite_q + BITE_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bite_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bite_q  <= bite_d;
        end
    end

    always_comb begin
        rst_req_o = (state_q == ST_BITE);
    end

    // R5: a count of one without a kick leads to a request next cycle
    p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !kick_i && cnt_q == CNT_W'(1)) |=> rst_req_o);

    // R6: a key write reloads the release period
    p_kick_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && kick_i) |=> (cnt_q == $past(p_rel)));

    // R7: without a key the count only steps down by one
    p_plain_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !kick_i && cnt_q > CNT_W'(1))
            |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R8: no request while disabled
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !rst_req_o);

    // R9: the end of a request resumes counting with the release period
    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_o) |-> (state_q == ST_COUNT && cnt_q == $past(p_rel)));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 32,
    parameter int BASE_EXP = 16,
    parameter int BITE_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);

    logic       en;
    logic       mode;
    logic       kick;
    logic [3:0] init_code;
    logic [3:0] rel_code;

    wdg_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .en_o        (en),
        .mode_o      (mode),
        .init_code_o (init_code),
        .rel_code_o  (rel_code),
        .kick_o      (kick)
    );

    wdg_core #(
        .CNT_W    (CNT_W),
        .BASE_EXP (BASE_EXP),
        .BITE_LEN (BITE_LEN)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .kick_i      (kick),
        .init_code_i (init_code),
        .rel_code_i  (rel_code),
        .rst_req_o   (rst_req)
    );

    // R2: the mode bit is storage only and never gates the request
    p_mode_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !mode) |-> en);

endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int BASE   = 2;
    localparam int BLEN   = 8;
    localparam int LIMIT  = 3000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              rst_req;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        int          at;
        bit          is_req;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_timer #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (32),
        .BASE_EXP (BASE),
        .BITE_LEN (BLEN)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rst_req   (rst_req)
    );

    function automatic int per(int code);
        return 1 << (BASE + code);
    endfunction

    task automatic wait_to(int n);
        while (cyc < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic push_req(int at, bit val, string tag);
        item_t it;
        it.at = at; it.is_req = 1'b1; it.exp = {31'b0, val}; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic read_at(int n, int addr, logic [31:0] exp, string tag);
        item_t it;
        wait_to(n);
        bus_addr = ADDR_W'(addr);
        it.at = n; it.is_req = 1'b0; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // write is taken on edge n
    task automatic write_at(int n, int addr, logic [31:0] data);
        wait_to(n - 1);
        bus_we = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
        @(posedge clk);
        #1;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    // monitor: pops every item due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                logic [31:0] act;
                act = sb[i].is_req ? {31'b0, rst_req} : bus_rdata;
                n_run++;
                if (act !== sb[i].exp) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: actual %h expected %h",
                             sb[i].tag, cyc, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > LIMIT) begin
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, LIMIT);
            $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
            $finish;
        end
    end

    initial begin
        int en_e, rise1, rise2, kick1, rise3, kick2, rise4;
        int left;
        wait_to(5);
        rst_n = 1'b1;

        // R1 reset state
        push_req(10, 1'b0, "R1");
        read_at(10, 'h0, 32'h0, "R1");
        read_at(11, 'h4, 32'h0, "R1");
        read_at(12, 'hC, 32'h0, "R11");

        // R4 timeout register: init code 3 (32), release code 5 (128)
        write_at(15, 'h4, 32'hFFFF_FF53);
        read_at(17, 'h4, 32'h0000_0053, "R4");

        // R10 key while disabled, R11 unmapped write and read
        write_at(20, 'hC, 32'h76);
        write_at(22, 'h8, 32'hFFFF_FFFF);
        read_at(24, 'h8, 32'h0, "R11");
        read_at(25, 'h0, 32'h0, "R11 unmapped write left ctrl");

        // R8 quiet while disabled
        push_req(30, 1'b0, "R8");
        push_req(80, 1'b0, "R8");
        push_req(150, 1'b0, "R8");

        // R5 enable with mode bit set
        en_e  = 160;
        rise1 = en_e + per(3) + 1;
        push_req(rise1 - 1, 1'b0, "R5 early");
        push_req(rise1, 1'b1, "R5 rise");
        push_req(rise1 + BLEN - 1, 1'b1, "R9 held");
        push_req(rise1 + BLEN, 1'b0, "R9 drop");
        rise2 = rise1 + BLEN + per(5);
        push_req(rise2 - 1, 1'b0, "R9 R10 resume");
        push_req(rise2, 1'b1, "R9 R10 second rise");
        write_at(en_e, 'h0, 32'h3);
        read_at(en_e + 2, 'h0, 32'h3, "R2");

        // R10 key during the request pulse
        write_at(rise1 + 3, 'hC, 32'h76);

        // R6 kick, R7 wrong key, R3 clear attempt
        kick1 = 400;
        rise3 = kick1 + per(5);
        push_req(rise3 - 1, 1'b0, "R6 R7 early");
        push_req(rise3, 1'b1, "R6 R7 rise");
        write_at(kick1, 'hC, 32'h0000_0076);
        write_at(450, 'hC, 32'h0000_0077);
        write_at(460, 'h0, 32'h0);
        read_at(462, 'h0, 32'h1, "R3");
        read_at(470, 'hC, 32'h0, "R11");

        // R4 code change applies at next load
        write_at(540, 'h4, 32'h23);
        read_at(542, 'h4, 32'h23, "R4");
        kick2 = 600;
        rise4 = kick2 + per(2);
        push_req(rise4 - 1, 1'b0, "R4 R6 early");
        push_req(rise4, 1'b1, "R4 R6 rise");
        push_req(rise4 + BLEN + per(2) - 1, 1'b0, "R9 new period");
        push_req(rise4 + BLEN + per(2), 1'b1, "R9 new period");
        push_req(590, 1'b0, "R4 old load still running");
        write_at(kick2, 'hC, 32'h76);

        wait_to(700);
        @(posedge clk);
        #1;
        left = sb.size();
        if (left != 0)
            $display("FAIL scoreboard: actual %0d items left expected 0", left);
        $display("  [TB] %0d tests run, %0d failed", n_run + left, n_fail + left);
        $finish;
    end

endmodule